// File: doc/BRIEF.md
# Double-Buffered Carrier Phase Generator

This block is the phase core of a numerically controlled oscillator. A simple address/data/write-strobe port loads a frequency word and a phase-offset word into staging registers. Nothing the oscillator uses changes until a commit moves a staged word into the register the accumulator reads. A commit comes either from a write to a dedicated commit address or, when armed, from an edge on an external sync pin. A sync edge commits both staged words in the same cycle, so several instances that share the sync line change frequency and phase together.

A 32-bit accumulator advances only on cycles that carry an input sample. Each step adds the committed frequency word plus an externally supplied carrier offset word. The output frequency therefore scales with the sample rate and not with the clock. The 10 most significant accumulator bits are offset by the committed phase word, modulo one full turn. The top 18 bits of that sum form a registered address for a sine/cosine table. A control bit can zero the accumulator on every commit, which lets several instances restart from a common phase.

Top module: `nco_phase_core`

## Requirements
- R1: While rst_ni is low, every register clears asynchronously and phase_o reads 0.
- R2: A write to address 0 stages wdata_i[31:0] as the frequency word, and a write to address 1 stages wdata_i[9:0] as the phase word. A staged word has no effect on phase_o until it is committed.
- R3: A write to address 2 copies the staged frequency word into the active frequency register at that same clock edge.
- R4: A write to address 3 copies the staged phase word into the active phase register at that same clock edge.
- R5: A write to address 4 sets the sync-arm bit from wdata_i[0] and the clear-on-commit bit from wdata_i[1]. While the sync-arm bit is 1, a rising edge on sync_i commits both staged words at the second clock edge after the edge on which the high level is first sampled. While the sync-arm bit is 0, sync_i has no effect.
- R6: sync_i held high for any number of cycles causes exactly one commit.
- R7: While the clear-on-commit bit is 1, any commit, whether by write or by sync, loads the accumulator with 0 at the commit edge, whatever the state of en_i.
- R8: At a clock edge where en_i is 1 and no clearing commit occurs, the accumulator becomes acc + active frequency + cof_i, modulo 2^32. The words used are those held before that edge. With en_i at 0, the accumulator holds.
- R9: At every clock edge, phase_o is loaded with {acc[31:22] + active phase (mod 2^10), acc[21:14]}, using the values from before that edge. This gives a latency of two edges from an enabled sample to the output.
- R10: cof_i is added to the step in every enabled cycle. Holding cof_i at 0 leaves the committed frequency as the step.
- R11: Writes to addresses 5 to 7 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Write address |
| wdata_i | input | 32 | Write data |
| sync_i | input | 1 | External commit pulse, asynchronous |
| en_i | input | 1 | Input-sample qualifier for the accumulator |
| cof_i | input | 32 | Carrier offset frequency, two's complement |
| phase_o | output | 18 | Registered phase address for the sine/cosine table |

## Verification
The assertions assume that en_i, we_i, addr_i, wdata_i and cof_i are synchronous to clk_i and hold steady around the active edge. The bench changes them only on the falling edge. The single-commit property for sync also assumes that sync_i is a level that the synchronizer samples cleanly. The bench therefore drives sync_i on the falling edge and holds each pulse for random lengths, including many cycles, together with concurrent writes and commits in the same cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FREQ_STG  = 3'd0,
    A_PHASE_STG = 3'd1,
    A_FREQ_CMT  = 3'd2,
    A_PHASE_CMT = 3'd3,
    A_CTRL      = 3'd4
  } nco_addr_e;

  localparam int unsigned CTRL_SYNC_ARM = 0;
  localparam int unsigned CTRL_CLR_CMT  = 1;
endpackage

// File: rtl/nco_sync_edge.sv
module nco_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sq;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq[0] <= 1'b0;
        else         sq[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq[g] <= 1'b0;
        else         sq[g] <= sq[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sq[STAGES-1];

  assign rise_o = sq[STAGES-1] & ~last_q;
endmodule

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PH_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ACC_W-1:0]  wdata_i,
  input  logic              sync_rise_i,
  output logic [ACC_W-1:0]  freq_act_o,
  output logic [PH_W-1:0]   phase_act_o,
  output logic              clr_cmt_o,
  output logic              sync_xfer_o,
  output logic              xfer_o
);
  logic [ACC_W-1:0] freq_stg_q;
  logic [PH_W-1:0]  phase_stg_q;
  logic             sync_arm_q, clr_cmt_q;
  logic             cmt_freq, cmt_phase;

  assign sync_xfer_o = sync_rise_i & sync_arm_q;
  assign cmt_freq    = (we_i && addr_i == A_FREQ_CMT) || sync_xfer_o;
  assign cmt_phase   = (we_i && addr_i == A_PHASE_CMT) || sync_xfer_o;
  assign xfer_o      = cmt_freq | cmt_phase;
  assign clr_cmt_o   = clr_cmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_stg_q  <= '0;
      phase_stg_q <= '0;
      freq_act_o  <= '0;
      phase_act_o <= '0;
      sync_arm_q  <= 1'b0;
      clr_cmt_q   <= 1'b0;
    end else begin
      if (we_i && addr_i == A_FREQ_STG)  freq_stg_q  <= wdata_i;
      if (we_i && addr_i == A_PHASE_STG) phase_stg_q <= wdata_i[PH_W-1:0];
      if (we_i && addr_i == A_CTRL) begin
        sync_arm_q <= wdata_i[CTRL_SYNC_ARM];
        clr_cmt_q  <= wdata_i[CTRL_CLR_CMT];
      end
      // commits take the staged value from before this edge
      if (cmt_freq)  freq_act_o  <= freq_stg_q;
      if (cmt_phase) phase_act_o <= phase_stg_q;
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PH_W  = 10,
  parameter int unsigned OUT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic [ACC_W-1:0] freq_i,
  input  logic [ACC_W-1:0] cof_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [OUT_W-1:0] phase_o
);
  localparam int unsigned LOW_W = OUT_W - PH_W;

  logic [ACC_W-1:0] step;
  logic [PH_W-1:0]  top_sum;

  assign step    = freq_i + cof_i;
  assign top_sum = acc_o[ACC_W-1 -: PH_W] + phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      phase_o <= '0;
    end else begin
      if (clear_i)   acc_o <= '0;
      else if (en_i) acc_o <= acc_o + step;
      phase_o <= {top_sum, acc_o[ACC_W-PH_W-1 -: LOW_W]};
    end
  end
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned PH_W      = 10,
  parameter int unsigned OUT_W     = 18,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ACC_W-1:0]  wdata_i,
  input  logic              sync_i,
  input  logic              en_i,
  input  logic [ACC_W-1:0]  cof_i,
  output logic [OUT_W-1:0]  phase_o
);
  logic             sync_rise, sync_xfer, xfer, clr_cmt, acc_clear;
  logic [ACC_W-1:0] freq_act, acc_w;
  logic [PH_W-1:0]  phase_act;

  nco_sync_edge #(.STAGES(SYNC_STGS)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(sync_i), .rise_o(sync_rise)
  );

  nco_ctrl_regs #(.ACC_W(ACC_W), .PH_W(PH_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sync_rise_i(sync_rise), .freq_act_o(freq_act),
    .phase_act_o(phase_act), .clr_cmt_o(clr_cmt), .sync_xfer_o(sync_xfer),
    .xfer_o(xfer)
  );

  assign acc_clear = xfer & clr_cmt;

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clear_i(acc_clear),
    .freq_i(freq_act), .cof_i(cof_i), .phase_i(phase_act),
    .acc_o(acc_w), .phase_o(phase_o)
  );
endmodule

// File: rtl/nco_phase_core_chk.sv
module nco_phase_core_chk #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PH_W  = 10,
  parameter int unsigned OUT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             clear_i,
  input logic             sync_xfer_i,
  input logic [ACC_W-1:0] freq_i,
  input logic [ACC_W-1:0] cof_i,
  input logic [PH_W-1:0]  phase_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [OUT_W-1:0] phase_o
);
  p_sync_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_xfer_i |=> !sync_xfer_i);

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_i == '0);

  p_acc_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=> acc_i == $past(acc_i + freq_i + cof_i));

  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(acc_i));

  p_out_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o[OUT_W-1 -: PH_W] ==
             $past(acc_i[ACC_W-1 -: PH_W] + phase_i));

  p_out_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o[OUT_W-PH_W-1:0] ==
             $past(acc_i[ACC_W-PH_W-1 -: OUT_W-PH_W]));

  always_comb if (!rst_ni) p_reset_out_r1: assert (phase_o == '0 || $isunknown(phase_o));
endmodule

bind nco_phase_core nco_phase_core_chk #(
  .ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clear_i(acc_clear),
  .sync_xfer_i(sync_xfer), .freq_i(freq_act), .cof_i(cof_i),
  .phase_i(phase_act), .acc_i(acc_w), .phase_o(phase_o)
);

// File: tb/test_nco_phase_core.sv
module test_nco_phase_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        sync = 1'b0;
  logic        en = 1'b0;
  logic [31:0] cof = '0;
  logic [17:0] phase;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  logic [31:0] m_fs = '0, m_fa = '0, m_acc = '0;
  logic [9:0]  m_ps = '0, m_pa = '0;
  logic        m_arm = 1'b0, m_clr = 1'b0;
  logic        m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;
  logic [17:0] m_out = '0;

  always #2.5 clk = ~clk;

  nco_phase_core i_nco_phase_core (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .sync_i(sync), .en_i(en), .cof_i(cof), .phase_o(phase)
  );

  function automatic logic [17:0] out_of(logic [31:0] a, logic [9:0] p);
    logic [9:0] t;
    t = a[31:22] + p;
    return {t, a[21:14]};
  endfunction

  always @(posedge clk) begin
    logic rise, sxf, cf, cp;
    logic [31:0] fs_old;
    logic [9:0]  ps_old;
    if (!rst_n) begin
      m_fs = '0; m_fa = '0; m_acc = '0; m_ps = '0; m_pa = '0;
      m_arm = 0; m_clr = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = '0;
    end else begin
      m_out  = out_of(m_acc, m_pa);
      rise   = m_s2 & ~m_prev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = sync;
      sxf    = rise & m_arm;
      cf     = (we && addr == 3'd2) || sxf;
      cp     = (we && addr == 3'd3) || sxf;
      fs_old = m_fs; ps_old = m_ps;
      if ((cf || cp) && m_clr) m_acc = '0;
      else if (en)             m_acc = m_acc + m_fa + cof;
      if (cf) m_fa = fs_old;
      if (cp) m_pa = ps_old;
      if (we && addr == 3'd0) m_fs = wdata;
      if (we && addr == 3'd1) m_ps = wdata[9:0];
      if (we && addr == 3'd4) begin m_arm = wdata[0]; m_clr = wdata[1]; end
    end
  end

  task automatic chk(input string t, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_o=%h expected %h at cycle %0d", t, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    chk(tag, phase, m_out);
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(3);
    chk("R1", phase, 18'h0);
    rst_n = 1'b1;

    tag = "R11";
    wr(3'd5, 32'hffff_ffff); wr(3'd6, 32'h1234_5678); wr(3'd7, 32'h3);
    en = 1'b1; idle(4); en = 1'b0; idle(2);
    chk("R11", phase, 18'h0);

    tag = "R2";
    wr(3'd0, 32'h0100_0000);
    en = 1'b1; idle(3); en = 1'b0; idle(2);
    chk("R2", phase, 18'h0);

    tag = "R3";
    wr(3'd2, 32'h0);
    @(negedge clk); en = 1'b1; idle(4); en = 1'b0; idle(2);
    chk("R3", phase, 18'h01000);   // acc 0x0400_0000

    tag = "R4";
    wr(3'd1, 32'h20); wr(3'd3, 32'h0); idle(2);
    chk("R4", phase, 18'h03000);

    tag = "R10";
    cof = 32'h0100_0000;
    @(negedge clk); en = 1'b1; @(negedge clk); en = 1'b0; cof = '0; idle(2);
    chk("R10", phase, 18'h03800);  // acc 0x0600_0000

    tag = "R7";
    wr(3'd4, 32'h2); wr(3'd2, 32'h0); idle(2);
    chk("R7", phase, 18'h02000);   // acc cleared, offset 0x20 remains

    tag = "R5";
    wr(3'd4, 32'h1); wr(3'd1, 32'h100); wr(3'd0, 32'h0);
    @(negedge clk); sync = 1'b1; @(negedge clk); sync = 1'b0; idle(4);
    chk("R5", phase, out_of(32'h0, 10'h100));
    wr(3'd4, 32'h0); wr(3'd1, 32'h3);
    @(negedge clk); sync = 1'b1; idle(2); sync = 1'b0; idle(4);
    chk("R5", phase, out_of(32'h0, 10'h100));

    tag = "R6";
    wr(3'd4, 32'h1); wr(3'd0, 32'h0000_4000);
    @(negedge clk); sync = 1'b1; en = 1'b1; idle(3);
    wr(3'd0, 32'h0800_0000);
    idle(8); sync = 1'b0; en = 1'b0; idle(3);
    chk("R6", phase, m_out);

    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      en = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) cof = ($urandom % 2) ? $urandom : '0;
      if (($urandom % 20) == 0) sync = ~sync;
      we = ($urandom % 3) == 0;
      addr = $urandom % 8;
      wdata = $urandom;
      if (addr == 3'd4 && ($urandom % 2)) wdata[1] = 1'b0;
    end
    @(negedge clk); we = 1'b0; en = 1'b0; sync = 1'b0; idle(4);
    tag = "R8";
    chk("R8", phase, out_of(m_acc, m_pa));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule